// File: doc/BRIEF.md
# Standby Refresh Mode Detector

This block is the device-side controller that decides when a dynamic memory array must be refreshed while the memory is in standby. It watches two pins: an active-low chip select and a shared active-low pin. While the chip is selected, the shared pin acts as an output enable. While the chip is deselected, it acts as a refresh command. The block times each low pulse on the shared pin and decides what the pulse means. A short pulse is noise and is dropped. A pulse of moderate width asks for one automatic refresh. A pulse that is held beyond a threshold puts the part into self refresh. In self refresh, an internal timer issues refreshes until the pin is released.

Each refresh leaves the block as a one-cycle request strobe. The strobe comes with the row to refresh, which is taken from an internal row counter that wraps. A separate flag shows that self refresh is active. The arming rule prevents a spurious refresh when an access ends with the shared pin still low: the pin must first be seen high in standby. All inputs are taken as synchronous to `clk`. The thresholds and the self-refresh period are given in clock cycles.

Top module: `refresh_mode_ctl`

## Requirements
- R1: After reset, `rf_req` is 0, `rf_row` is 0 and `self_active` is 0.
- R2: While `chip_sel_n` is 0, the block issues no request. A low pulse on `oe_rf_n` during selection produces no refresh.
- R3: Detection is armed only after `oe_rf_n` has been sampled high while `chip_sel_n` is 1. A low level already present when standby begins is ignored, however long it lasts, until the pin goes high and falls again.
- R4: A low pulse of N sampled cycles, with MIN_LOW_CYC ≤ N ≤ SELF_THRESH_CYC, produces exactly one request. That request is high in the cycle after the first clock edge that samples the pin high again.
- R5: A low pulse with N < MIN_LOW_CYC is ignored. It issues no request and does not advance the row.
- R6: When the pin is sampled low on edge SELF_THRESH_CYC+1 of a pulse, `self_active` rises and a request is issued on that same edge. Further requests follow every SELF_PERIOD_CYC cycles while the pin stays low. A pulse of N > SELF_THRESH_CYC gives 1 + (N−SELF_THRESH_CYC−1)/SELF_PERIOD_CYC requests (integer division).
- R7: In self refresh, sampling `oe_rf_n` high clears `self_active` on that edge and stops the requests.
- R8: Sampling `chip_sel_n` low clears `self_active` on that edge, and no later request is issued. A request that was already issued still completes its cycle.
- R9: `rf_row` holds the row of the current request while `rf_req` is high. It advances by one after each request, in both modes, and wraps from ROWS−1 (2047 by default) to 0.
- R10: `rf_req` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Chip select, active low; high means standby |
| oe_rf_n | input | 1 | Shared output-enable / refresh command pin, active low |
| rf_req | output | 1 | One-cycle refresh request to the array |
| rf_row | output | ROW_W | Row to refresh; valid while rf_req is high |
| self_active | output | 1 | High while self refresh is running |

## Verification
Each result has a fixed latency in cycles.
- An automatic refresh request appears one cycle after the edge that first samples the pin high.
- Self-refresh entry raises both the request and `self_active` one cycle after low sample SELF_THRESH_CYC+1.
- Later self-refresh requests fall exactly SELF_PERIOD_CYC cycles apart.
- An exit, whether by the pin or by chip select, drops `self_active` one cycle after it is sampled.

The bench drives inputs on falling edges and reads outputs on the following falling edges, one edge count after the stimulus. Requests are counted by a monitor after each pulse has settled, so counts are compared only once no further request can arrive.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
   typedef enum logic [1:0] {
      ST_DISARM = 2'd0,
      ST_ARMED  = 2'd1,
      ST_LOW    = 2'd2,
      ST_SELF   = 2'd3
   } rfm_state_e;
endpackage

// File: rtl/rfm_pulse_meter.sv
module rfm_pulse_meter
   import rfm_pkg::*;
#(
   parameter int unsigned MIN_LOW_CYC     = 20,
   parameter int unsigned SELF_THRESH_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic standby,
   input  logic pin_low,
   output logic fire,
   output logic in_self
);
   localparam int unsigned CNT_W = $clog2(SELF_THRESH_CYC + 2);
   localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LOW_CYC);
   localparam logic [CNT_W-1:0] THR_C = CNT_W'(SELF_THRESH_CYC);

   rfm_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      fire    = 1'b0;
      if (!standby) begin
         state_d = ST_DISARM;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            ST_DISARM: if (!pin_low) state_d = ST_ARMED;
            ST_ARMED: if (pin_low) begin
               state_d = ST_LOW;
               cnt_d   = CNT_W'(1);
            end
            ST_LOW: begin
               if (!pin_low) begin
                  state_d = ST_ARMED;
                  cnt_d   = '0;
                  fire    = (cnt_q >= MIN_C);
               end else if (cnt_q == THR_C) begin
                  state_d = ST_SELF;
                  cnt_d   = '0;
                  fire    = 1'b1;
               end else begin
                  cnt_d = cnt_q + CNT_W'(1);
               end
            end
            ST_SELF: if (!pin_low) state_d = ST_ARMED;
            default: state_d = ST_DISARM;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_DISARM;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign in_self = (state_q == ST_SELF);

   // R3: a disarmed detector never begins timing a pulse directly
   assert_arm_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DISARM) |=> (state_q != ST_LOW));

   // R7: releasing the pin in self refresh returns to the armed state
   assert_self_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SELF && standby && !pin_low) |=> (state_q == ST_ARMED));
endmodule

// File: rtl/rfm_self_timer.sv
module rfm_self_timer #(
   parameter int unsigned SELF_PERIOD_CYC = 3906
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned TM_W = $clog2(SELF_PERIOD_CYC + 1);
   localparam logic [TM_W-1:0] LAST = TM_W'(SELF_PERIOD_CYC - 1);

   logic [TM_W-1:0] tm_q;

   assign tick = run && (tm_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tm_q <= '0;
      else if (!run || tick)     tm_q <= '0;
      else                       tm_q <= tm_q + TM_W'(1);
   end

   // R6: the interval counter never passes its last value
   assert_tm_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tm_q <= LAST);
endmodule

// File: rtl/rfm_row_ctr.sv
module rfm_row_ctr #(
   parameter int unsigned ROW_W = 11,
   parameter int unsigned ROWS  = 2048
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [ROW_W-1:0] row
);
   localparam logic [ROW_W-1:0] TOP = ROW_W'(ROWS - 1);

   logic [ROW_W-1:0] row_q, row_inc;

   generate
      if (ROWS == (1 << ROW_W)) begin : g_natural_wrap
         assign row_inc = row_q + ROW_W'(1);
      end else begin : g_compare_wrap
         assign row_inc = (row_q == TOP) ? '0 : row_q + ROW_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    row_q <= '0;
      else if (step) row_q <= row_inc;
   end

   assign row = row_q;

   // R9: each served request advances the row by one with wrap
   assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (row_q == (($past(row_q) == TOP) ? '0 : $past(row_q) + ROW_W'(1))));

   // R9: the row never leaves the legal range
   assert_row_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      row_q <= TOP);
endmodule

// File: rtl/refresh_mode_ctl.sv
module refresh_mode_ctl #(
   parameter int unsigned ROW_W           = 11,
   parameter int unsigned ROWS            = 2048,
   parameter int unsigned MIN_LOW_CYC     = 20,
   parameter int unsigned SELF_THRESH_CYC = 2000,
   parameter int unsigned SELF_PERIOD_CYC = 3906
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_sel_n,
   input  logic             oe_rf_n,
   output logic             rf_req,
   output logic [ROW_W-1:0] rf_row,
   output logic             self_active
);
   initial begin : param_checks
      if (ROWS < 2 || ROWS > (1 << ROW_W)) $fatal(1, "ROWS out of range for ROW_W");
      if (MIN_LOW_CYC < 1)                 $fatal(1, "MIN_LOW_CYC must be at least 1");
      if (SELF_THRESH_CYC < MIN_LOW_CYC)   $fatal(1, "threshold below minimum width");
      if (SELF_PERIOD_CYC < 2)             $fatal(1, "SELF_PERIOD_CYC must be at least 2");
   end

   logic standby, pin_low;
   logic meter_fire, in_self, timer_tick;
   logic req_q;

   assign standby = chip_sel_n;
   assign pin_low = !oe_rf_n;

   rfm_pulse_meter #(
      .MIN_LOW_CYC    (MIN_LOW_CYC),
      .SELF_THRESH_CYC(SELF_THRESH_CYC)
   ) u_meter (
      .clk    (clk),
      .rst_n  (rst_n),
      .standby(standby),
      .pin_low(pin_low),
      .fire   (meter_fire),
      .in_self(in_self)
   );

   rfm_self_timer #(
      .SELF_PERIOD_CYC(SELF_PERIOD_CYC)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (in_self && standby && pin_low),
      .tick (timer_tick)
   );

   rfm_row_ctr #(
      .ROW_W(ROW_W),
      .ROWS (ROWS)
   ) u_rows (
      .clk  (clk),
      .rst_n(rst_n),
      .step (req_q),
      .row  (rf_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= meter_fire || timer_tick;
   end

   assign rf_req      = req_q;
   assign self_active = in_self;

   // R2: no request follows a cycle in which the chip was selected
   assert_no_req_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_sel_n |=> !rf_req);

   // R8: selection ends self refresh on the next cycle
   assert_select_cancels_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_sel_n |=> !self_active);

   // R10: requests are single-cycle strobes
   assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rf_req |=> !rf_req);

   // R6: self refresh is entered only together with a request
   assert_self_entry_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(self_active) |-> rf_req);
endmodule

// File: tb/tb_refresh_mode_ctl.sv
module tb_refresh_mode_ctl;
   localparam int unsigned ROW_W  = 11;
   localparam int unsigned ROWS   = 2048;
   localparam int unsigned MINC   = 4;
   localparam int unsigned THR    = 20;
   localparam int unsigned PER    = 10;
   localparam int NVEC = 8;
   localparam int VEC_N   [NVEC] = '{3, 4, 12, 20, 21, 30, 31, 51};
   localparam int VEC_EXP [NVEC] = '{0, 1,  1,  1,  1,  1,  2,  4};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_sel_n = 1'b0;
   logic oe_rf_n = 1'b1;
   logic rf_req, self_active;
   logic [ROW_W-1:0] rf_row;

   int total = 0;
   int bad = 0;
   int req_cnt = 0;
   int exp_row = 0;
   bit prev_req = 1'b0;
   bit seen_wrap = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   refresh_mode_ctl #(
      .ROW_W(ROW_W), .ROWS(ROWS), .MIN_LOW_CYC(MINC),
      .SELF_THRESH_CYC(THR), .SELF_PERIOD_CYC(PER)
   ) dut (
      .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .oe_rf_n(oe_rf_n),
      .rf_req(rf_req), .rf_row(rf_row), .self_active(self_active)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: row sequence (R9) and single-cycle strobe (R10)
   always @(negedge clk) begin
      if (rst_n) begin
         if (rf_req) begin
            req_cnt++;
            chk(int'(rf_row) == exp_row, "R9 row", int'(rf_row), exp_row);
            if (exp_row == 0 && req_cnt > 1) seen_wrap = 1'b1;
            exp_row = (exp_row + 1) % ROWS;
         end
         if (rf_req && prev_req) chk(1'b0, "R10 strobe", 2, 1);
         prev_req = rf_req;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic arm();
      chip_sel_n = 1'b1;
      oe_rf_n = 1'b1;
      cyc(3);
   endtask

   task automatic pulse(input int n, input int expc, input string tag);
      int base;
      arm();
      base = req_cnt;
      oe_rf_n = 1'b0;
      cyc(n);
      if (n > THR) chk(self_active == 1'b1, {tag, " self on"}, int'(self_active), 1);
      oe_rf_n = 1'b1;
      cyc(4);
      #1;
      chk(req_cnt - base == expc, tag, req_cnt - base, expc);
      chk(self_active == 1'b0, "R7 self off", int'(self_active), 0);
   endtask

   initial begin : watchdog
      #(4 * 200000);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int base;
      cyc(3);
      #1;
      chk(rf_req == 1'b0, "R1 req", int'(rf_req), 0);
      chk(rf_row == '0, "R1 row", int'(rf_row), 0);
      chk(self_active == 1'b0, "R1 self", int'(self_active), 0);
      rst_n = 1'b1;
      cyc(2);

      // vector table: widths and expected request counts (R4, R5, R6)
      for (int i = 0; i < NVEC; i++) begin
         string t;
         t = (VEC_N[i] < int'(MINC)) ? "R5 short" : (VEC_N[i] <= int'(THR)) ? "R4 auto" : "R6 self";
         pulse(VEC_N[i], VEC_EXP[i], t);
      end

      // R4 latency: request in the cycle after the first high sample
      arm();
      oe_rf_n = 1'b0;
      cyc(6);
      oe_rf_n = 1'b1;
      chk(rf_req == 1'b0, "R4 before", int'(rf_req), 0);
      cyc(1);
      chk(rf_req == 1'b1, "R4 timing", int'(rf_req), 1);
      cyc(1);
      chk(rf_req == 1'b0, "R10 drop", int'(rf_req), 0);

      // R6 timing: entry on low sample THR+1, then every PER cycles
      arm();
      oe_rf_n = 1'b0;
      cyc(THR);
      chk(rf_req == 1'b0 && self_active == 1'b0, "R6 pre-entry", int'(rf_req), 0);
      cyc(1);
      chk(rf_req == 1'b1 && self_active == 1'b1, "R6 entry", int'(rf_req), 1);
      cyc(PER - 1);
      chk(rf_req == 1'b0, "R6 gap", int'(rf_req), 0);
      cyc(1);
      chk(rf_req == 1'b1, "R6 period", int'(rf_req), 1);
      // R7: release ends self refresh
      oe_rf_n = 1'b1;
      cyc(1);
      chk(self_active == 1'b0, "R7 exit", int'(self_active), 0);

      // R2: pulses while selected are not refresh commands
      chip_sel_n = 1'b0;
      cyc(2);
      base = req_cnt;
      oe_rf_n = 1'b0;
      cyc(8);
      oe_rf_n = 1'b1;
      cyc(4);
      oe_rf_n = 1'b0;
      cyc(40);
      oe_rf_n = 1'b1;
      cyc(3);
      #1;
      chk(req_cnt == base, "R2 selected", req_cnt - base, 0);

      // R3: low already held when standby begins is ignored
      oe_rf_n = 1'b0;
      cyc(2);
      chip_sel_n = 1'b1;
      cyc(40);
      #1;
      chk(req_cnt == base && self_active == 1'b0, "R3 disarmed", req_cnt - base, 0);
      oe_rf_n = 1'b1;
      cyc(2);
      oe_rf_n = 1'b0;
      cyc(6);
      oe_rf_n = 1'b1;
      cyc(3);
      #1;
      chk(req_cnt == base + 1, "R3 rearmed", req_cnt - base, 1);

      // R8: selection cancels self refresh
      arm();
      oe_rf_n = 1'b0;
      cyc(THR + 5);
      chip_sel_n = 1'b0;
      cyc(1);
      chk(self_active == 1'b0, "R8 cancel", int'(self_active), 0);
      base = req_cnt;
      cyc(3 * PER);
      #1;
      chk(req_cnt == base, "R8 no more req", req_cnt - base, 0);
      oe_rf_n = 1'b1;

      // R9 wrap: long self refresh passes row ROWS-1
      arm();
      oe_rf_n = 1'b0;
      cyc(THR + 1 + 2100 * PER);
      oe_rf_n = 1'b1;
      cyc(4);
      #1;
      chk(seen_wrap, "R9 wrap", int'(seen_wrap), 1);
      chk(int'(rf_row) == exp_row, "R9 row after wrap", int'(rf_row), exp_row);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule